// File: doc/BRIEF.md
# Secure Memory Range Permission Checker

This block sits on the memory-controller side and screens every memory access against a small table of protected address ranges. Software fills the table through a plain 32-bit register write/read port. For each access presented (an address plus a read/write flag) the block answers in the same cycle with either allow or abort. It also raises a flag when a denied read should be answered with zero data rather than an error. The data substitution itself is done elsewhere.

Each table entry describes one naturally aligned region whose size is a power of two, together with its access permission. Addresses that no valid entry covers fall under a default policy, which is held in spare bits of entry 0. A sticky lock bit in the control register freezes the table. A separate security bit, once set, makes the configuration port ignore writes that are not marked secure.

Top module: `smr_checker`

## Requirements
- R1: After reset every range entry reads 0 (invalid), the default permission is read/write, the lock bit and the security bit are 0, every configuration offset reads 0, and every access is allowed.
- R2: The low word of entry i sits at offset 0x80+8*i and holds bit 0 valid, bits 2:1 permission, bit 3 read-zero enable, bits 11:7 size code and bits 31:12 start address, and reads back as written. Bits 6:4 are stored only in entry 0 and read 0 in every other entry. The high word at 0x84+8*i reads 0 and ignores writes.
- R3: An entry matches an access when it is valid and (addr >> (code+12)) equals (start >> (code+12)). A region therefore spans 4 KB << code. Start bits below the region size are ignored. Codes of 20 and above cover the whole 32-bit space.
- R4: An entry with a size code below 8 never matches, whatever its other fields hold.
- R5: The permission codes are: 0 allows reads and writes, 1 allows reads only, 2 allows writes only, and 3 aborts every access. While acc_valid_i is 1, exactly one of acc_allow_o and acc_abort_o is 1. While it is 0, all three verdict outputs are 0.
- R6: When several entries match, the lowest-numbered one decides.
- R7: An address matched by no entry takes its permission from entry 0 bits 5:4 and its read-zero enable from entry 0 bit 6. This holds whether or not entry 0 is valid.
- R8: acc_rzero_o is 1 exactly when a read is aborted and the deciding region has its read-zero enable set: bit 3 of the deciding entry, or bit 6 of entry 0 for the default region.
- R9: Writing 1 to bit 31 of the control register at offset 0x044 sets the lock. That bit reads back as 1 and every other bit of the register reads 0. Only reset clears the lock. While it is set, writes to the range registers are ignored.
- R10: Bit 0 of the security register at offset 0x048 is stored when written. While it is 1, any configuration write with cfg_secure_i = 0 is ignored, including writes to the control register and to the security register itself. Secure writes still take effect.
- R11: The verdict is combinational: the outputs follow the access inputs and the table contents within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_secure_i | input | 1 | Configuration write is issued by a secure master |
| cfg_addr_i | input | CFG_AW | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i, combinational |
| acc_valid_i | input | 1 | An access is presented |
| acc_write_i | input | 1 | Access is a write (1) or a read (0) |
| acc_addr_i | input | 32 | Access byte address |
| acc_allow_o | output | 1 | Access is permitted |
| acc_abort_o | output | 1 | Access is denied |
| acc_rzero_o | output | 1 | Denied read is to be answered with zero data |

## Verification
Each table configuration is swept with two sets of addresses. A coarse grid covers the whole 4 GB space. A set of boundary probes sits at each entry's first byte, its last byte and the bytes just outside it, and each probe is tried both as a read and as a write. The boundary probes separate correct size masking and misaligned-start handling from off-by-one errors. Overlapping entries are placed in both index orders, which exposes a wrong priority direction. The configurations cover a table cleared by reset, mixed overlapping entries, entries that are inert (invalid or too small), an invalid entry 0 that still supplies the default, and a whole-space code. A full read map of the configuration offsets, together with secure and non-secure writes before and after lock, shows which writes land and which are dropped.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned GRAN_SHIFT = 12;
  localparam int unsigned CODE_W     = 5;
  localparam int unsigned MIN_CODE   = 8;
  localparam int unsigned START_W    = ADDR_W - GRAN_SHIFT;

  localparam int unsigned CTRL_OFS   = 32'h044;
  localparam int unsigned SEC_OFS    = 32'h048;
  localparam int unsigned RANGE_BASE = 32'h080;
  localparam int unsigned LOCK_BIT   = 31;

  typedef enum logic [1:0] {
    PERM_RW    = 2'd0,
    PERM_RO    = 2'd1,
    PERM_WO    = 2'd2,
    PERM_ABORT = 2'd3
  } perm_e;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic [CODE_W-1:0]  code;
    logic               rz;
    perm_e              perm;
    logic               valid;
  } range_t;

  function automatic range_t word_to_range(input logic [31:0] w);
    range_t r;
    r.start = w[31:12];
    r.code  = w[11:7];
    r.rz    = w[3];
    r.perm  = perm_e'(w[2:1]);
    r.valid = w[0];
    return r;
  endfunction

  function automatic logic [31:0] range_to_word(input range_t r);
    return {r.start, r.code, 3'b000, r.rz, r.perm, r.valid};
  endfunction
endpackage

// File: rtl/smr_cfg_regs.sv
module smr_cfg_regs
  import smr_pkg::*;
#(
  parameter int unsigned N_RANGES = 16,
  parameter int unsigned CFG_AW   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic                      cfg_secure_i,
  input  logic [CFG_AW-1:0]         cfg_addr_i,
  input  logic [31:0]               cfg_wdata_i,
  output logic [31:0]               cfg_rdata_o,
  output range_t [N_RANGES-1:0]     ranges_o,
  output perm_e                     def_perm_o,
  output logic                      def_rz_o
);
  localparam int unsigned IDX_W     = (N_RANGES > 1) ? $clog2(N_RANGES) : 1;
  localparam int unsigned RANGE_END = RANGE_BASE + 8 * N_RANGES;

  logic [31:0]      ofs;
  logic [31:0]      rel;
  logic             in_tab;
  logic             hi_word;
  logic [IDX_W-1:0] idx;
  logic             wr_ok;
  logic             tab_we;
  logic             lock_q;
  logic             sec_q;
  perm_e            def_perm_q;
  logic             def_rz_q;

  assign ofs     = 32'(cfg_addr_i);
  assign rel     = ofs - RANGE_BASE;
  assign in_tab  = (ofs >= RANGE_BASE) && (ofs < RANGE_END) && (ofs[1:0] == 2'b00);
  assign hi_word = ofs[2];
  assign idx     = IDX_W'(rel >> 3);
  // non-secure writes are dropped once the security bit is set
  assign wr_ok   = cfg_we_i && (!sec_q || cfg_secure_i);
  assign tab_we  = wr_ok && !lock_q && in_tab && !hi_word;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_ent
    range_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               ent_q <= '0;
      else if (tab_we && (idx == IDX_W'(g)))     ent_q <= word_to_range(cfg_wdata_i);
    end
    assign ranges_o[g] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      def_perm_q <= PERM_RW;
      def_rz_q   <= 1'b0;
    end else if (tab_we && (idx == '0)) begin
      def_perm_q <= perm_e'(cfg_wdata_i[5:4]);
      def_rz_q   <= cfg_wdata_i[6];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                 lock_q <= 1'b0;
    else if (wr_ok && (ofs == CTRL_OFS) && cfg_wdata_i[LOCK_BIT]) lock_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sec_q <= 1'b0;
    else if (wr_ok && (ofs == SEC_OFS))   sec_q <= cfg_wdata_i[0];
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (in_tab && !hi_word) begin
      cfg_rdata_o = range_to_word(ranges_o[idx]);
      if (idx == '0) cfg_rdata_o[6:4] = {def_rz_q, def_perm_q};
    end else if (ofs == CTRL_OFS) begin
      cfg_rdata_o[LOCK_BIT] = lock_q;
    end else if (ofs == SEC_OFS) begin
      cfg_rdata_o[0] = sec_q;
    end
  end

  assign def_perm_o = def_perm_q;
  assign def_rz_o   = def_rz_q;

  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_table_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(ranges_o) && $stable(def_perm_q) && $stable(def_rz_q)));

  assert_ns_write_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q && cfg_we_i && !cfg_secure_i) |=>
      ($stable(ranges_o) && $stable(lock_q) && $stable(sec_q) && $stable(def_perm_q)));
endmodule

// File: rtl/smr_range_match.sv
module smr_range_match
  import smr_pkg::*;
(
  input  logic                      valid_i,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [START_W-1:0]        start_i,
  input  logic [ADDR_W-1:GRAN_SHIFT] page_i,
  output logic                      hit_o
);
  logic [START_W-1:0] bit_ok;

  // a bit is compared only when it lies at or above the region size
  for (genvar b = 0; b < START_W; b++) begin : g_bit
    logic above;
    assign above     = (32'(code_i) <= 32'(b));
    assign bit_ok[b] = !above || (page_i[GRAN_SHIFT+b] == start_i[b]);
  end

  assign hit_o = valid_i && (32'(code_i) >= MIN_CODE) && (&bit_ok);
endmodule

// File: rtl/smr_decide.sv
module smr_decide
  import smr_pkg::*;
#(
  parameter int unsigned N_RANGES = 16
) (
  input  logic [N_RANGES-1:0]  hits_i,
  input  perm_e [N_RANGES-1:0] perms_i,
  input  logic [N_RANGES-1:0]  rz_i,
  input  perm_e                def_perm_i,
  input  logic                 def_rz_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  output logic [N_RANGES-1:0]  grant_o,
  output logic                 allow_o,
  output logic                 abort_o,
  output logic                 rzero_o
);
  logic  found;
  perm_e sel_perm;
  logic  sel_rz;
  logic  permitted;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N_RANGES; i++) begin
      if (hits_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    sel_perm = def_perm_i;
    sel_rz   = def_rz_i;
    for (int i = 0; i < N_RANGES; i++) begin
      if (grant_o[i]) begin
        sel_perm = perms_i[i];
        sel_rz   = rz_i[i];
      end
    end
  end

  always_comb begin
    unique case (sel_perm)
      PERM_RW:    permitted = 1'b1;
      PERM_RO:    permitted = !acc_write_i;
      PERM_WO:    permitted = acc_write_i;
      default:    permitted = 1'b0;
    endcase
  end

  assign allow_o = acc_valid_i && permitted;
  assign abort_o = acc_valid_i && !permitted;
  assign rzero_o = abort_o && !acc_write_i && sel_rz;
endmodule

// File: rtl/smr_checker.sv
module smr_checker
  import smr_pkg::*;
#(
  parameter int unsigned N_RANGES = 16,
  parameter int unsigned CFG_AW   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_secure_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [31:0]       acc_addr_i,
  output logic              acc_allow_o,
  output logic              acc_abort_o,
  output logic              acc_rzero_o
);
  range_t [N_RANGES-1:0] ranges;
  perm_e  [N_RANGES-1:0] perms;
  logic   [N_RANGES-1:0] rzs;
  logic   [N_RANGES-1:0] hits;
  logic   [N_RANGES-1:0] grant;
  perm_e                 def_perm;
  logic                  def_rz;
  logic                  unused_low;

  assign unused_low = ^acc_addr_i[GRAN_SHIFT-1:0];

  smr_cfg_regs #(.N_RANGES(N_RANGES), .CFG_AW(CFG_AW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_secure_i (cfg_secure_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .ranges_o     (ranges),
    .def_perm_o   (def_perm),
    .def_rz_o     (def_rz)
  );

  for (genvar g = 0; g < N_RANGES; g++) begin : g_match
    assign perms[g] = ranges[g].perm;
    assign rzs[g]   = ranges[g].rz;
    smr_range_match u_match (
      .valid_i (ranges[g].valid),
      .code_i  (ranges[g].code),
      .start_i (ranges[g].start),
      .page_i  (acc_addr_i[ADDR_W-1:GRAN_SHIFT]),
      .hit_o   (hits[g])
    );
  end

  smr_decide #(.N_RANGES(N_RANGES)) u_decide (
    .hits_i      (hits),
    .perms_i     (perms),
    .rz_i        (rzs),
    .def_perm_i  (def_perm),
    .def_rz_i    (def_rz),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .grant_o     (grant),
    .allow_o     (acc_allow_o),
    .abort_o     (acc_abort_o),
    .rzero_o     (acc_rzero_o)
  );

  assert_verdict_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> (acc_allow_o != acc_abort_o));

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !(acc_allow_o || acc_abort_o || acc_rzero_o));

  assert_single_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~hits) == '0) && ((|hits) == (|grant)));

  assert_rzero_on_denied_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rzero_o |-> (acc_abort_o && !acc_write_i));
endmodule

// File: tb/smr_checker_test.sv
module smr_checker_test;
  localparam int unsigned N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sec = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        allow, abort_s, rzero;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] mdl [N];
  bit m_lock = 1'b0;
  bit m_sec = 1'b0;

  always #10 clk = ~clk;

  smr_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_secure_i(cfg_sec),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .acc_allow_o(allow), .acc_abort_o(abort_s), .acc_rzero_o(rzero)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int unsigned o = 32'(a);
    if (o >= 32'h80 && o < 32'h80 + 8 * N && o[1:0] == 2'b00) begin
      if (o[2]) return 32'h0;
      return mdl[(o - 32'h80) >> 3];
    end
    if (o == 32'h44) return {m_lock, 31'b0};
    if (o == 32'h48) return {31'b0, m_sec};
    return 32'h0;
  endfunction

  function automatic logic [2:0] exp_acc(input logic [31:0] a, input logic wr);
    logic [1:0] p = mdl[0][5:4];
    logic rz = mdl[0][6];
    logic ok;
    for (int i = N - 1; i >= 0; i--) begin
      int unsigned code = 32'(mdl[i][11:7]);
      int unsigned s = code + 12;
      logic [63:0] aa = {32'b0, a};
      logic [63:0] ss = {32'b0, mdl[i] & 32'hFFFF_F000};
      if (mdl[i][0] && code >= 8 && ((aa >> s) == (ss >> s))) begin
        p = mdl[i][2:1];
        rz = mdl[i][3];
      end
    end
    ok = (p == 2'd0) || (p == 2'd1 && !wr) || (p == 2'd2 && wr);
    return {ok, !ok, !ok && !wr && rz};
  endfunction

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d, input bit sec);
    int unsigned o = 32'(a);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_sec = sec; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sec = 1'b0;
    if (!(m_sec && !sec)) begin
      if (o == 32'h48) m_sec = d[0];
      if (o == 32'h44 && d[31]) m_lock = 1'b1;
      if (!m_lock && o >= 32'h80 && o < 32'h80 + 8 * N && o[2:0] == 3'b000)
        mdl[(o - 32'h80) >> 3] = d & (((o - 32'h80) >> 3) == 0 ? 32'hFFFF_FFFF : 32'hFFFF_FF8F);
    end
  endtask

  task automatic read_check(input string tag, input logic [11:0] a);
    cfg_addr = a;
    #1;
    check($sformatf("%s read @%h", tag, a), cfg_rdata, exp_read(a));
  endtask

  task automatic read_map(input string tag);
    for (int o = 0; o < 256; o += 4) read_check(tag, 12'(o));
  endtask

  task automatic probe(input string tag, input logic [31:0] a);
    for (int w = 0; w < 2; w++) begin
      acc_valid = 1'b1; acc_addr = a; acc_write = w[0];
      #1;
      check($sformatf("%s acc %h wr=%0d {allow,abort,rzero}", tag, a, w),
            {29'b0, allow, abort_s, rzero}, {29'b0, exp_acc(a, w[0])});
    end
  endtask

  // grid over the whole space plus boundary probes around every entry
  task automatic sweep(input string tag);
    @(negedge clk);
    for (int k = 0; k < 256; k++) probe(tag, 32'(k) << 24 | 32'h0012_3450);
    for (int i = 0; i < N; i++) begin
      int unsigned s = 32'(mdl[i][11:7]) + 12;
      logic [63:0] sz = 64'd1 << s;
      logic [63:0] base = {32'b0, mdl[i] & 32'hFFFF_F000} & ~(sz - 1);
      probe(tag, base[31:0]);
      probe(tag, 32'(base - 1));
      probe(tag, 32'(base + sz - 1));
      probe(tag, 32'(base + sz));
    end
    acc_valid = 1'b0;
  endtask

  function automatic logic [31:0] ent(input logic [31:0] start, input int code,
                                      input int perm, input bit rz, input bit v);
    return start | (32'(code) << 7) | (32'(rz) << 3) | (32'(perm) << 1) | 32'(v);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    #5;
    #1 check("R1 allow in reset (idle)", {31'b0, allow}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_map("R1");
    sweep("R1 reset");

    // R5 idle outputs
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h0010_0000; acc_write = 1'b0;
    #1 check("R5 idle outputs", {29'b0, allow, abort_s, rzero}, 32'h0);

    // R2 R3 R4 R6 R8 mixed table
    cfg_write(12'h080, ent(32'h0010_0000, 8, 1, 1, 1) | (32'd1 << 6) | (32'd2 << 4), 1'b0);
    cfg_write(12'h088, ent(32'h0020_0000, 9, 2, 0, 1), 1'b0);
    cfg_write(12'h090, ent(32'h0000_0000, 12, 3, 1, 1), 1'b0);
    cfg_write(12'h098, ent(32'h0350_0000, 10, 0, 0, 1) | (32'd7 << 4), 1'b0);
    cfg_write(12'h0A0, ent(32'h8000_0000, 5, 3, 1, 1), 1'b0);
    cfg_write(12'h0A8, ent(32'h9000_0000, 12, 3, 1, 0), 1'b0);
    cfg_write(12'h0B0, ent(32'h2000_0000, 16, 1, 0, 1), 1'b0);
    cfg_write(12'h0B8, ent(32'h2800_0000, 8, 3, 1, 1), 1'b0);
    cfg_write(12'h084, 32'hFFFF_FFFF, 1'b0);
    read_map("R2");
    sweep("R3/R4/R5/R6/R8/R11 mixed");
    @(negedge clk);
    probe("R4 small-code entry inert", 32'h8000_0000);
    probe("R6 lower index wins", 32'h0010_0000);
    probe("R6 lower index wins over e7", 32'h2800_0000);
    probe("R3 misaligned start", 32'h0340_0000);

    // R7 default from invalid entry 0
    cfg_write(12'h080, ent(32'h0010_0000, 8, 1, 1, 0) | (32'd1 << 6) | (32'd3 << 4), 1'b0);
    sweep("R7 default");

    // R3 whole-space code
    cfg_write(12'h0F8, ent(32'h0000_0000, 31, 1, 0, 1), 1'b0);
    sweep("R3 whole space");

    // R10 security bit
    cfg_write(12'h048, 32'h1, 1'b1);
    read_check("R10 sec set", 12'h048);
    cfg_write(12'h090, ent(32'h4000_0000, 8, 0, 0, 1), 1'b0);
    read_check("R10 ns write dropped", 12'h090);
    cfg_write(12'h048, 32'h0, 1'b0);
    read_check("R10 ns clear dropped", 12'h048);
    cfg_write(12'h044, 32'h8000_0000, 1'b0);
    read_check("R10 ns lock dropped", 12'h044);
    cfg_write(12'h090, ent(32'h4000_0000, 8, 2, 0, 1), 1'b1);
    read_check("R10 secure write lands", 12'h090);
    sweep("R10 after writes");

    // R9 lock
    cfg_write(12'h044, 32'hFFFF_FFFF, 1'b1);
    read_check("R9 lock readback", 12'h044);
    cfg_write(12'h044, 32'h0, 1'b1);
    read_check("R9 lock sticky", 12'h044);
    cfg_write(12'h088, 32'h0, 1'b1);
    cfg_write(12'h080, 32'h0, 1'b1);
    read_map("R9 locked");
    cfg_write(12'h048, 32'h0, 1'b1);
    read_check("R10 secure clear", 12'h048);
    sweep("R9 locked");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule